// File: doc/BRIEF.md
# Supply Status Handshake Checker

This carrier-side block runs a two-phase query against a test peripheral that reports the health of its supply rails over three return lines. The block owns one outgoing mode line. It first holds the mode line high and samples the three status lines after a settle interval. It then drives the mode line low, waits the same interval and samples them again. The peripheral answers with true polarity while the mode line is high and with inverted polarity while it is low.

The two samples are used in two ways. A rail counts as good only when its line reads 1 in the high phase and 0 in the low phase. Separately, each status line is marked continuous only if its value flipped between the phases. The mode line itself is marked continuous when at least one status line flipped. A stuck or open pin therefore shows up as a continuity fault, and its rail is never reported good. The results are registered and held, and a one-cycle done pulse marks each finished query.

Top module: `supply_handshake_chk`

## Requirements
- R1: After synchronous reset, mode_o is 1, rail_good and line_ok are all 0, and done is 0.
- R2: A start pulse seen while idle begins a query. Counting from the clock edge that samples start, mode_o stays high for SETTLE_CYC cycles and then low for exactly SETTLE_CYC cycles. done rises on the edge 2*SETTLE_CYC cycles after the start edge.
- R3: done is high for exactly one cycle, and mode_o is back at 1 in that same cycle.
- R4: Index mapping is shared by stat_in and rail_good: bit 0 is the 5V line, bit 1 the 3.3V line and bit 2 the VIO line. rail_good[i] is 1 only when stat_in[i] was 1 at the end of the high phase and 0 at the end of the low phase.
- R5: line_ok[i], for i in 0..2, is 1 exactly when stat_in[i] differed between the two phase samples. A line whose value is equal in both phases reads line_ok[i]=0 and rail_good[i]=0.
- R6: line_ok[3] reports the mode line and is 1 exactly when at least one status line differed between the two phases.
- R7: A start pulse that arrives while a query is in progress is ignored. The query keeps its timing and produces a single done.
- R8: rail_good and line_ok change only on the cycle in which done is high, and they hold their values between queries.
- R9: stat_in passes through a two-flop synchroniser, and each phase sample is taken at the last cycle of that phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run a query |
| stat_in | input | 3 | Returned status lines (0: 5V, 1: 3.3V, 2: VIO) |
| mode_o | output | 1 | Mode line driven to the peripheral |
| rail_good | output | 3 | Per-rail good flags, same index as stat_in |
| line_ok | output | 4 | Continuity per line (0..2 status lines, 3 mode line) |
| done | output | 1 | One-cycle pulse when a query completes |

## Verification
The rail decode and the continuity flags are both produced from the same pair of phase samples. They are written on the same edge that raises done, so a fault on one line must clear that rail's good flag while the other rails still decode normally. This is provoked by running queries in which some rails are good, others are bad, and a chosen line is held stuck at 0 or 1, or the mode line is cut at the peripheral. On the done cycle the bench compares every rail_good and line_ok bit against the value its peripheral model predicts for that mix.

// File: rtl/shk_pkg.sv
package shk_pkg;
  localparam int NRAIL = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HI   = 2'd1,
    ST_LO   = 2'd2
  } shk_state_e;

  typedef struct packed {
    logic [NRAIL-1:0] good;
    logic [NRAIL:0]   ok;
  } shk_result_t;
endpackage

// File: rtl/shk_sync.sv
module shk_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '0;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/shk_seq.sv
module shk_seq
  import shk_pkg::*;
#(
  parameter int SETTLE_CYC = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic mode_o,
  output logic cap_hi,
  output logic cap_lo
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  shk_state_e st;
  logic [CW-1:0] cnt;
  logic          last;

  assign last   = (cnt == LAST);
  assign cap_hi = (st == ST_HI) && last;
  assign cap_lo = (st == ST_LO) && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      mode_o <= 1'b1;
    end else begin
      case (st)
        ST_IDLE: begin
          cnt    <= '0;
          mode_o <= 1'b1;
          if (start) st <= ST_HI;
        end
        ST_HI: begin
          if (last) begin
            st     <= ST_LO;
            cnt    <= '0;
            mode_o <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_LO: begin
          if (last) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            mode_o <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          st     <= ST_IDLE;
          cnt    <= '0;
          mode_o <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/shk_eval.sv
module shk_eval
  import shk_pkg::*;
#(
  parameter int N = NRAIL
) (
  input  logic [N-1:0] hi,
  input  logic [N-1:0] lo,
  output shk_result_t  res
);
  logic [N-1:0] flip;

  generate
    for (genvar i = 0; i < N; i++) begin : g_line
      assign flip[i]        = hi[i] ^ lo[i];
      assign res.good[i]    = hi[i] & ~lo[i];
      assign res.ok[i]      = flip[i];
    end
  endgenerate

  assign res.ok[N] = |flip;
endmodule

// File: rtl/supply_handshake_chk.sv
module supply_handshake_chk
  import shk_pkg::*;
#(
  parameter int SETTLE_CYC  = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NRAIL-1:0] stat_in,
  output logic             mode_o,
  output logic [NRAIL-1:0] rail_good,
  output logic [NRAIL:0]   line_ok,
  output logic             done
);
  logic [NRAIL-1:0] stat_s;
  logic [NRAIL-1:0] hi_q;
  logic             cap_hi;
  logic             cap_lo;
  shk_result_t      res;

  shk_sync #(.W(NRAIL), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (stat_in),
    .q   (stat_s)
  );

  shk_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .mode_o (mode_o),
    .cap_hi (cap_hi),
    .cap_lo (cap_lo)
  );

  shk_eval #(.N(NRAIL)) u_eval (
    .hi  (hi_q),
    .lo  (stat_s),
    .res (res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q      <= '0;
      rail_good <= '0;
      line_ok   <= '0;
      done      <= 1'b0;
    end else begin
      done <= cap_lo;
      if (cap_hi) hi_q <= stat_s;
      if (cap_lo) begin
        rail_good <= res.good;
        line_ok   <= res.ok;
      end
    end
  end
endmodule

// File: rtl/shk_chk.sv
module shk_chk #(
  parameter int SETTLE_CYC = 1024
) (
  input logic       clk,
  input logic       rst,
  input logic       mode_o,
  input logic [2:0] rail_good,
  input logic [3:0] line_ok,
  input logic       done
);
  int lowcnt;

  always_ff @(posedge clk) begin
    if (rst)          lowcnt <= 0;
    else if (!mode_o) lowcnt <= lowcnt + 1;
    else              lowcnt <= 0;
  end

  assert_low_phase_len_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_o) |-> (lowcnt == SETTLE_CYC));

  assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_mode_idle_at_done_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> mode_o);

  assert_good_needs_flip_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> ((rail_good & ~line_ok[2:0]) == 3'b000));

  assert_mode_line_flag_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> (line_ok[3] == (line_ok[2:0] != 3'b000)));

  assert_hold_good_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(rail_good) |-> done);

  assert_hold_ok_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(line_ok) |-> done);
endmodule

bind supply_handshake_chk shk_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mode_o    (mode_o),
  .rail_good (rail_good),
  .line_ok   (line_ok),
  .done      (done)
);

// File: tb/sim_supply_handshake_chk.sv
module sim_supply_handshake_chk;
  localparam int S = 16;
  localparam int NV = 10;
  // [16:14] good  [13:11] stuck enable  [10:8] stuck value  [7] mode open
  // [6:4] expected rail_good  [3:0] expected line_ok
  localparam logic [16:0] VEC [NV] = '{
    17'b111_000_000_0_111_1111,
    17'b000_000_000_0_000_1111,
    17'b101_000_000_0_101_1111,
    17'b010_000_000_0_010_1111,
    17'b111_001_000_0_110_1110,
    17'b111_010_010_0_101_1101,
    17'b111_111_101_0_000_0000,
    17'b111_000_000_1_000_0000,
    17'b000_100_100_0_000_1011,
    17'b110_001_001_0_110_1110
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [2:0] stat_in;
  logic mode_o, done;
  logic [2:0] rail_good;
  logic [3:0] line_ok;

  logic [2:0] p_good = 3'b000;
  logic [2:0] p_sen  = 3'b000;
  logic [2:0] p_sval = 3'b000;
  logic       p_mopen = 1'b0;
  logic       mode_seen;

  int errors = 0;
  int checks = 0;
  int done_seen = 0;

  always #4 clk = ~clk;

  supply_handshake_chk #(.SETTLE_CYC(S)) u0 (
    .clk(clk), .rst(rst), .start(start), .stat_in(stat_in),
    .mode_o(mode_o), .rail_good(rail_good), .line_ok(line_ok), .done(done)
  );

  // peripheral model: true polarity when mode high, inverted when low
  always_comb begin
    mode_seen = p_mopen ? 1'b1 : mode_o;
    for (int i = 0; i < 3; i++)
      stat_in[i] = p_sen[i] ? p_sval[i] : (mode_seen ? p_good[i] : ~p_good[i]);
  end

  always @(posedge clk) if (!rst && done) done_seen++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_query(input int poke_at, output int cyc, output int lowc);
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    lowc = 0;
    while (!done && cyc < 4 * S + 50) begin
      if (!mode_o) lowc++;
      if (cyc == poke_at) start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cyc, lowc, d0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 mode_o", mode_o, 1);
    chk("R1 rail_good", rail_good, 0);
    chk("R1 line_ok", line_ok, 0);
    chk("R1 done", done, 0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      p_good  = VEC[v][16:14];
      p_sen   = VEC[v][13:11];
      p_sval  = VEC[v][10:8];
      p_mopen = VEC[v][7];
      run_query(-1, cyc, lowc);
      chk("R2 start-to-done cycles", cyc, 2 * S);
      chk("R2 low phase length", lowc, S);
      chk("R4 rail_good", rail_good, VEC[v][6:4]);
      chk("R5 line_ok status lines", line_ok[2:0], VEC[v][2:0]);
      chk("R6 line_ok mode line", line_ok[3], VEC[v][3]);
      chk("R3 mode_o high at done", mode_o, 1);
      @(posedge clk);
      @(negedge clk);
      chk("R3 done width", done, 0);
    end

    // R7: second start mid-run ignored
    p_good = 3'b011; p_sen = 3'b000; p_sval = 3'b000; p_mopen = 1'b0;
    d0 = done_seen;
    run_query(S + 3, cyc, lowc);
    chk("R7 timing kept", cyc, 2 * S);
    chk("R7 result", rail_good, 3'b011);
    repeat (3 * S) @(posedge clk);
    @(negedge clk);
    chk("R7 single done", done_seen - d0, 1);
    chk("R7 idle mode_o", mode_o, 1);

    // R8: results hold while peripheral changes between queries
    p_good = 3'b100; p_sen = 3'b111; p_sval = 3'b000;
    repeat (2 * S) @(posedge clk);
    @(negedge clk);
    chk("R8 hold rail_good", rail_good, 3'b011);
    chk("R8 hold line_ok", line_ok, 4'b1111);

    // R9: status change just before low-phase sample is lost in synchroniser
    p_good = 3'b111; p_sen = 3'b000; p_mopen = 1'b0;
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    repeat (2 * S - 2) @(negedge clk);
    p_sen = 3'b001; p_sval = 3'b001;
    @(negedge clk);
    @(negedge clk);
    chk("R9 done reached", done, 1);
    chk("R9 late change not sampled", rail_good, 3'b111);
    p_sen = 3'b000;

    // R1: reset again after activity
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 rail_good after reset", rail_good, 0);
    chk("R1 line_ok after reset", line_ok, 0);
    rst = 1'b0;

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule